// File: doc/BRIEF.md
# Data Access Alignment Handler

This block sits in the address path of a load/store unit. For every data access it takes a 32-bit byte address and an access size (byte, halfword or word). It produces the 30-bit word address and the four byte-lane strobes that go onto the memory bus. It also decides whether the access is aligned to its own size.

A misaligned access is handled in one of two ways, chosen by a trap-enable bit taken from the status register. With the bit set, the access is not issued: the bus request and strobes stay at zero, a one-cycle fault pulse is raised, and the full faulting byte address is captured for software. With the bit clear, the address is rounded down to the size boundary and the access goes out as a single bus cycle. It is never split across two words.

The results are registered. They appear one cycle after a request is accepted, behind a valid/ready handshake to the bus stage.

Top module: `align_unit`

## Requirements
- R1: After reset, `bus_valid`, `bus_strobe`, `fault` and `fault_addr` are all zero and `req_ready` is high.
- R2: One cycle after an accepted access that is issued, `bus_valid` is high and `bus_waddr` equals byte-address bits [31:2].
- R3: A byte access (size code 0) is never misaligned. Its strobe is one-hot, with bit n set for address bits [1:0] = n.
- R4: A halfword access (size code 1) is misaligned when address bit 0 is 1. Its strobe is 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1.
- R5: A word access (size code 2) is misaligned when address bits [1:0] are not zero. Its strobe is 4'b1111.
- R6: A misaligned access accepted with `trap_en` high is not issued. In the next cycle `bus_valid` is 0, `bus_strobe` is 0 and `fault` is 1 for exactly one cycle, and `fault_addr` holds the full 32-bit byte address.
- R7: A misaligned access accepted with `trap_en` low is issued. It is rounded down to its size boundary, raises no fault and leaves `fault_addr` unchanged.
- R8: While `bus_valid` is high and `bus_ready` is low, `req_ready` is low and `bus_waddr`/`bus_strobe` stay stable.
- R9: `fault_addr` changes only in the cycle in which `fault` is raised.
- R10: Size code 3 behaves exactly like a word access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Handler can accept a request |
| req_addr | input | 32 | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 word |
| trap_en | input | 1 | Status bit: trap on misalignment when 1 |
| bus_valid | output | 1 | Bus access issued |
| bus_ready | input | 1 | Bus stage takes the access |
| bus_waddr | output | 30 | Word address on the bus |
| bus_strobe | output | 4 | Byte-lane strobes |
| fault | output | 1 | One-cycle misalignment fault pulse |
| fault_addr | output | 32 | Byte address of the last faulting access |

## Verification
Every result (word address, strobes, valid, fault pulse and captured fault address) passes through exactly one register. It is therefore due one clock edge after the edge at which the request is accepted. Each scenario task drives its inputs on a falling edge and lets one rising edge accept the request. It reads the outputs on the following falling edge, then drops the request before the next rising edge. For the stall case the bench holds `bus_ready` low over extra edges. It checks that nothing moves until the edge after `bus_ready` returns high.

// File: rtl/align_pkg.sv
package align_pkg;
  localparam int LANES = 4;
  localparam int OFF_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  // Low-offset bits that must be zero for an access of this size.
  function automatic logic [OFF_W-1:0] span_mask(acc_size_e sz);
    case (sz)
      SZ_BYTE: span_mask = '0;
      SZ_HALF: span_mask = OFF_W'(1);
      default: span_mask = '1;
    endcase
  endfunction

  // First lane of the access after rounding down to its size boundary.
  function automatic logic [OFF_W-1:0] lane_base(logic [OFF_W-1:0] off, acc_size_e sz);
    lane_base = off & ~span_mask(sz);
  endfunction
endpackage

// File: rtl/align_check.sv
module align_check
  import align_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  input  acc_size_e        size_i,
  output logic             misal_o,
  output logic [LANES-1:0] lanes_o
);
  logic [OFF_W-1:0] mask;
  logic [OFF_W-1:0] base;

  assign mask    = span_mask(size_i);
  assign base    = lane_base(off_i, size_i);
  assign misal_o = |(off_i & mask);

  // A lane is enabled when its index, with the in-span bits cleared, hits the base.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE_IDX = OFF_W'(g);
    assign lanes_o[g] = ((LANE_IDX & ~mask) == base);
  end

  always_comb begin
    if (size_i == SZ_BYTE) begin
      AST_BYTE_NEVER_MISAL: assert (!misal_o); // R3
    end
  end
endmodule

// File: rtl/align_outreg.sv
module align_outreg #(
  parameter int WADDR_W = 30,
  parameter int LANES_P = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_i,
  input  logic               trap_i,
  input  logic [WADDR_W-1:0] waddr_i,
  input  logic [LANES_P-1:0] lanes_i,
  input  logic               bus_ready_i,
  output logic               bus_valid_o,
  output logic [WADDR_W-1:0] waddr_o,
  output logic [LANES_P-1:0] strobe_o,
  output logic               fault_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_valid_o <= 1'b0;
      waddr_o     <= '0;
      strobe_o    <= '0;
      fault_o     <= 1'b0;
    end else begin
      fault_o <= acc_i && trap_i;
      if (acc_i) begin
        bus_valid_o <= !trap_i;
        waddr_o     <= trap_i ? '0 : waddr_i;
        strobe_o    <= trap_i ? '0 : lanes_i;
      end else if (bus_ready_i) begin
        bus_valid_o <= 1'b0;
        strobe_o    <= '0;
      end
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(waddr_o) && $stable(strobe_o)); // R8

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid_o |-> strobe_o == '0); // R6

  AST_FAULT_NOT_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !bus_valid_o); // R6

  AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o && !acc_i |=> !fault_o); // R6
endmodule

// File: rtl/align_fault_latch.sv
module align_fault_latch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              fault_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     addr_o <= '0;
    else if (cap_i) addr_o <= addr_i;
  end

  AST_FAULT_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_i |-> $stable(addr_o)); // R9
endmodule

// File: rtl/align_unit.sv
module align_unit
  import align_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [1:0]              req_size,
  input  logic                    trap_en,
  output logic                    bus_valid,
  input  logic                    bus_ready,
  output logic [ADDR_W-OFF_W-1:0] bus_waddr,
  output logic [LANES-1:0]        bus_strobe,
  output logic                    fault,
  output logic [ADDR_W-1:0]       fault_addr
);
  localparam int WADDR_W = ADDR_W - OFF_W;

  logic             accept;
  logic             misal;
  logic             trap_hit;
  logic [LANES-1:0] lanes;

  assign req_ready = !bus_valid || bus_ready;
  assign accept    = req_valid && req_ready;
  assign trap_hit  = misal && trap_en;

  align_check u_check (
    .off_i   (req_addr[OFF_W-1:0]),
    .size_i  (acc_size_e'(req_size)),
    .misal_o (misal),
    .lanes_o (lanes)
  );

  align_outreg #(.WADDR_W(WADDR_W), .LANES_P(LANES)) u_outreg (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_i       (accept),
    .trap_i      (trap_hit),
    .waddr_i     (req_addr[ADDR_W-1:OFF_W]),
    .lanes_i     (lanes),
    .bus_ready_i (bus_ready),
    .bus_valid_o (bus_valid),
    .waddr_o     (bus_waddr),
    .strobe_o    (bus_strobe),
    .fault_o     (fault)
  );

  align_fault_latch #(.ADDR_W(ADDR_W)) u_flatch (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_i   (accept && trap_hit),
    .addr_i  (req_addr),
    .fault_i (fault),
    .addr_o  (fault_addr)
  );

  AST_STALL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |-> !req_ready); // R8

  AST_ISSUE_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> $past(req_valid)); // R2
endmodule

// File: tb/align_unit_tb.sv
module align_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        trap_en = 1'b0;
  logic        bus_valid;
  logic        bus_ready = 1'b1;
  logic [29:0] bus_waddr;
  logic [3:0]  bus_strobe;
  logic        fault;
  logic [31:0] fault_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  align_unit u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_strobe(logic [31:0] a, logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b0001 << a[1:0];
      2'd1:    return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic exp_misal(logic [31:0] a, logic [1:0] sz);
    case (sz)
      2'd0:    return 1'b0;
      2'd1:    return a[0];
      default: return a[1:0] != 2'b00;
    endcase
  endfunction

  // Present one request, let one rising edge accept it, sample at the next falling edge.
  task automatic issue(input logic [31:0] a, input logic [1:0] sz, input logic te);
    @(negedge clk);
    req_addr = a; req_size = sz; trap_en = te; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_issued(input string req, input logic [31:0] a, input logic [1:0] sz);
    chk(req, {31'd0, bus_valid}, 32'd1);
    chk(req, {2'd0, bus_waddr}, {2'd0, a[31:2]});
    chk(req, {28'd0, bus_strobe}, {28'd0, exp_strobe(a, sz)});
    chk(req, {31'd0, fault}, 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid", {31'd0, bus_valid}, 32'd0);
    chk("R1 strobe", {28'd0, bus_strobe}, 32'd0);
    chk("R1 fault", {31'd0, fault}, 32'd0);
    chk("R1 faddr", fault_addr, 32'd0);
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_bytes();
    for (int i = 0; i < 4; i++) begin
      logic [31:0] a = 32'h1234_5670 + 32'(i);
      issue(a, 2'd0, 1'b1);
      expect_issued("R3 byte", a, 2'd0);
    end
  endtask

  task automatic t_halves();
    issue(32'h0000_0100, 2'd1, 1'b1); expect_issued("R4 half lo", 32'h0000_0100, 2'd1);
    issue(32'hFFFF_FFFE, 2'd1, 1'b1); expect_issued("R4 half hi", 32'hFFFF_FFFE, 2'd1);
    issue(32'h0000_0203, 2'd1, 1'b0); expect_issued("R4 R7 half round", 32'h0000_0203, 2'd1);
    chk("R4 half round strobe", {28'd0, bus_strobe}, 32'h0000_000C);
  endtask

  task automatic t_words();
    issue(32'h5555_5554, 2'd2, 1'b1); expect_issued("R5 R2 word", 32'h5555_5554, 2'd2);
    issue(32'hFFFF_FFFC, 2'd2, 1'b1); expect_issued("R5 R2 word top", 32'hFFFF_FFFC, 2'd2);
    issue(32'hAAAA_AAA8, 2'd3, 1'b1); expect_issued("R10 size3", 32'hAAAA_AAA8, 2'd3);
  endtask

  task automatic t_trap();
    logic [31:0] a = 32'hAAAA_AAAA;
    chk("R5 misal model", {31'd0, exp_misal(a, 2'd2)}, 32'd1);
    issue(a, 2'd2, 1'b1);
    chk("R6 no valid", {31'd0, bus_valid}, 32'd0);
    chk("R6 no strobe", {28'd0, bus_strobe}, 32'd0);
    chk("R6 fault", {31'd0, fault}, 32'd1);
    chk("R6 faddr", fault_addr, a);
    @(negedge clk);
    chk("R6 fault one cycle", {31'd0, fault}, 32'd0);
    chk("R9 faddr held", fault_addr, a);
    issue(32'h0000_0011, 2'd1, 1'b1);
    chk("R4 R6 half trap", {31'd0, fault}, 32'd1);
    chk("R4 R6 half faddr", fault_addr, 32'h0000_0011);
    issue(32'h0000_0013, 2'd3, 1'b1);
    chk("R10 size3 trap", {31'd0, fault}, 32'd1);
  endtask

  task automatic t_round();
    issue(32'hAAAA_AAAA, 2'd2, 1'b0);
    expect_issued("R7 word round", 32'hAAAA_AAAA, 2'd2);
    chk("R7 waddr", {2'd0, bus_waddr}, 32'h2AAA_AAAA);
    chk("R7 R9 faddr unchanged", fault_addr, 32'h0000_0013);
  endtask

  task automatic t_stall();
    @(negedge clk); @(negedge clk);
    bus_ready = 1'b0;
    issue(32'h0000_1000, 2'd2, 1'b1);
    expect_issued("R8 first", 32'h0000_1000, 2'd2);
    req_addr = 32'h0000_2001; req_size = 2'd0; trap_en = 1'b1; req_valid = 1'b1;
    chk("R8 ready low", {31'd0, req_ready}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R8 held waddr", {2'd0, bus_waddr}, 32'h0000_0400);
    chk("R8 held strobe", {28'd0, bus_strobe}, 32'h0000_000F);
    bus_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    expect_issued("R8 second", 32'h0000_2001, 2'd0);
    @(posedge clk); @(negedge clk);
    chk("R8 drained", {31'd0, bus_valid}, 32'd0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_bytes();
        t_halves();
        t_words();
        t_trap();
        t_round();
        t_stall();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule